// File: doc/BRIEF.md
# Real-Time Stream Frame Splitter

This block sits on the receive side of one Ethernet port and takes frames as a byte stream, one byte per valid cycle, with a last-byte marker. It reads the fixed Ethernet, IPv4 and UDP header fields while the frame passes. A frame that belongs to one of the configured real-time UDP streams is split in two. Its 42 header bytes go to a header ring and everything after them goes to a payload ring. Every other frame is copied whole into a general ring for host software. A typical stream frame has a 1024-byte payload. Each port gets its own instance.

The three rings are on-chip RAMs. Each has its own read port: a read strobe, a byte that arrives one cycle later, and a count of the bytes a reader may take. Bytes are written ahead of a speculative pointer. The pointer a reader sees moves only on the last byte of a frame, so a half-written frame is never visible. When a destination ring runs out of room partway through a frame, the whole frame is thrown away in every ring and a drop counter goes up by one.

Top module: `rtss_splitter`

## Requirements
- R1: A frame matches when all of these hold: byte 12 is 0x08 and byte 13 is 0x00 (IPv4 type), byte 23 is 17 (UDP), bytes 36 and 37 (most significant byte first) equal the port value of an enabled slot, and the frame is at least 42 bytes long. Bytes are numbered from 0.
- R2: For a matching frame, bytes 0 to 41 are committed in order to the header ring and bytes 42 onward to the payload ring. The general ring does not change.
- R3: A non-matching frame, including any frame shorter than 42 bytes, is committed whole and in order to the general ring. The header and payload rings do not change.
- R4: Byte 14 must be exactly 0x45 (version 4, five-word IP header). Any other value makes the frame non-matching, even when all other fields match.
- R5: A slot whose enable bit is 0 never produces a match, whatever its port value is.
- R6: Ring levels never rise in the middle of a frame. They rise only in the cycle after the frame's last byte.
- R7: If a destination ring lacks room for its share of a frame, no ring keeps any byte of that frame and the drop counter increases by exactly 1. Each ring holds at most its depth in committed bytes.
- R8: A read strobe while a ring's level is non-zero returns the oldest committed byte on the read data one cycle later and lowers the level by 1. A read strobe while the level is 0 has no effect.
- R9: After reset, all three levels and the drop counter are 0.
- R10: A matching frame of exactly 42 bytes commits 42 header bytes and no payload bytes.
- R11: With default depths, two matching frames with 1024-byte payloads fit in the payload ring. A third one, sent before any read, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the frame's final byte |
| cfg_port | input | NSLOT*16 | UDP destination port per slot, slot i at bits [16i+15:16i] |
| cfg_en | input | NSLOT | Enable per slot |
| hdr_rd_en | input | 1 | Header ring read strobe |
| hdr_rd_data | output | 8 | Header ring read byte |
| hdr_level | output | $clog2(HDR_DEPTH)+1 | Committed bytes in header ring |
| data_rd_en | input | 1 | Payload ring read strobe |
| data_rd_data | output | 8 | Payload ring read byte |
| data_level | output | $clog2(DATA_DEPTH)+1 | Committed bytes in payload ring |
| gen_rd_en | input | 1 | General ring read strobe |
| gen_rd_data | output | 8 | General ring read byte |
| gen_level | output | $clog2(GEN_DEPTH)+1 | Committed bytes in general ring |
| drop_cnt | output | CNT_W | Frames discarded for lack of room |

## Verification
The hardest case to reach is a matching frame that fits in one of its two rings but not in the other. The ring that did have room must then give back its speculative bytes, and the general ring, which was also written during the header, must be rolled back. To get there, the stimulus holds off all reads. It fills the payload ring with two full-size stream frames and then sends a third. Separately, it fills the header ring with six short stream frames before sending a seventh. After each drop, every ring is drained and its contents are compared byte by byte with the model. Random frames with one corrupted field each, along with short truncated frames, cover the header-decision boundary at byte 41.

// File: rtl/rtss_pkg.sv
package rtss_pkg;
    localparam int HDR_BYTES = 42;
    localparam int IDX_W     = $clog2(HDR_BYTES + 1);
    localparam int OFF_TYPE_HI = 12;
    localparam int OFF_TYPE_LO = 13;
    localparam int OFF_VER_IHL = 14;
    localparam int OFF_PROTO   = 23;
    localparam int OFF_DPORT_HI = 36;
    localparam int OFF_DPORT_LO = 37;

    typedef enum logic [1:0] {
        RT_IDLE,
        RT_SPECULATE,   // header phase: header ring and general ring both written
        RT_PAYLOAD,     // split frame body to payload ring
        RT_GENERAL      // unsplit frame body to general ring
    } route_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             fields_ok;
        logic [15:0]      dport;
        logic             split;
    } parse_st_t;

    function automatic logic fixed_field_ok(input logic [IDX_W-1:0] idx, input logic [7:0] b);
        case (int'(idx))
            OFF_TYPE_HI: return b == 8'h08;
            OFF_TYPE_LO: return b == 8'h00;
            OFF_VER_IHL: return b == 8'h45;
            OFF_PROTO:   return b == 8'd17;
            default:     return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/rtss_ring.sv
module rtss_ring #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          fin,
    input  logic          keep,
    output logic          ovf_now,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] level
);
    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] spec_ptr, commit_ptr, rd_ptr, spec_nx;
    logic          ovf_q, full, do_wr, do_rd;

    assign full    = (spec_ptr - rd_ptr) == LW'(DEPTH);
    assign do_wr   = wr_en && !full;
    assign ovf_now = ovf_q || (wr_en && full);
    assign spec_nx = spec_ptr + LW'(do_wr);
    assign level   = commit_ptr - rd_ptr;
    assign do_rd   = rd_en && (level != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[spec_ptr[AW-1:0]] <= wr_data;
        if (do_rd) rd_data <= mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_ptr   <= '0;
            commit_ptr <= '0;
            rd_ptr     <= '0;
            ovf_q      <= 1'b0;
        end else begin
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (fin) begin
                ovf_q <= 1'b0;
                if (keep && !ovf_now) begin
                    commit_ptr <= spec_nx;
                    spec_ptr   <= spec_nx;
                end else begin
                    spec_ptr   <= commit_ptr;
                end
            end else begin
                spec_ptr <= spec_nx;
                ovf_q    <= ovf_now;
            end
        end
    end
endmodule

// File: rtl/rtss_parse.sv
module rtss_parse
    import rtss_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    input  logic [NSLOT*16-1:0] cfg_port,
    input  logic [NSLOT-1:0]   cfg_en,
    output logic               in_hdr,
    output logic               split_body,
    output logic               frame_split
);
    parse_st_t       st;
    logic [NSLOT-1:0] slot_hit;
    logic            hit_at_end;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_hit[s] = cfg_en[s] && (cfg_port[s*16 +: 16] == st.dport);
    end

    assign hit_at_end  = st.fields_ok && (|slot_hit);
    assign in_hdr      = int'(st.idx) < HDR_BYTES;
    assign split_body  = st.split;
    assign frame_split = (int'(st.idx) == HDR_BYTES - 1) ? hit_at_end :
                         (int'(st.idx) == HDR_BYTES)     ? st.split   : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{idx: '0, fields_ok: 1'b1, dport: '0, split: 1'b0};
        end else if (in_valid) begin
            if (in_last) begin
                st <= '{idx: '0, fields_ok: 1'b1, dport: '0, split: 1'b0};
            end else begin
                if (in_hdr) st.idx <= st.idx + 1'b1;
                if (!fixed_field_ok(st.idx, in_data)) st.fields_ok <= 1'b0;
                if (int'(st.idx) == OFF_DPORT_HI) st.dport[15:8] <= in_data;
                if (int'(st.idx) == OFF_DPORT_LO) st.dport[7:0]  <= in_data;
                if (int'(st.idx) == HDR_BYTES - 1) st.split <= hit_at_end;
            end
        end
    end
endmodule

// File: rtl/rtss_splitter.sv
module rtss_splitter
    import rtss_pkg::*;
#(
    parameter int NSLOT      = 4,
    parameter int HDR_DEPTH  = 256,
    parameter int DATA_DEPTH = 2048,
    parameter int GEN_DEPTH  = 1024,
    parameter int CNT_W      = 16,
    localparam int HLW = $clog2(HDR_DEPTH) + 1,
    localparam int DLW = $clog2(DATA_DEPTH) + 1,
    localparam int GLW = $clog2(GEN_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    input  logic [NSLOT*16-1:0] cfg_port,
    input  logic [NSLOT-1:0]    cfg_en,
    input  logic                hdr_rd_en,
    output logic [7:0]          hdr_rd_data,
    output logic [HLW-1:0]      hdr_level,
    input  logic                data_rd_en,
    output logic [7:0]          data_rd_data,
    output logic [DLW-1:0]      data_level,
    input  logic                gen_rd_en,
    output logic [7:0]          gen_rd_data,
    output logic [GLW-1:0]      gen_level,
    output logic [CNT_W-1:0]    drop_cnt
);
    logic   in_hdr, split_body, frame_split, fin;
    logic   hdr_ovf, data_ovf, gen_ovf, lost;
    route_e route;

    rtss_parse #(.NSLOT(NSLOT)) u_parse (
        .clk, .rst, .in_valid, .in_data, .in_last, .cfg_port, .cfg_en,
        .in_hdr, .split_body, .frame_split
    );

    always_comb begin
        if (!in_valid)       route = RT_IDLE;
        else if (in_hdr)     route = RT_SPECULATE;
        else if (split_body) route = RT_PAYLOAD;
        else                 route = RT_GENERAL;
    end

    assign fin  = in_valid && in_last;
    assign lost = frame_split ? (hdr_ovf || data_ovf) : gen_ovf;

    rtss_ring #(.DEPTH(HDR_DEPTH)) u_hdr_ring (
        .clk, .rst,
        .wr_en(route == RT_SPECULATE), .wr_data(in_data),
        .fin, .keep(frame_split && !data_ovf), .ovf_now(hdr_ovf),
        .rd_en(hdr_rd_en), .rd_data(hdr_rd_data), .level(hdr_level)
    );

    rtss_ring #(.DEPTH(DATA_DEPTH)) u_data_ring (
        .clk, .rst,
        .wr_en(route == RT_PAYLOAD), .wr_data(in_data),
        .fin, .keep(frame_split && !hdr_ovf), .ovf_now(data_ovf),
        .rd_en(data_rd_en), .rd_data(data_rd_data), .level(data_level)
    );

    rtss_ring #(.DEPTH(GEN_DEPTH)) u_gen_ring (
        .clk, .rst,
        .wr_en(route == RT_SPECULATE || route == RT_GENERAL), .wr_data(in_data),
        .fin, .keep(!frame_split), .ovf_now(gen_ovf),
        .rd_en(gen_rd_en), .rd_data(gen_rd_data), .level(gen_level)
    );

    always_ff @(posedge clk) begin
        if (rst)              drop_cnt <= '0;
        else if (fin && lost) drop_cnt <= drop_cnt + 1'b1;
    end
endmodule

// File: rtl/rtss_splitter_chk.sv
module rtss_splitter_chk #(
    parameter int HDR_DEPTH  = 256,
    parameter int DATA_DEPTH = 2048,
    parameter int GEN_DEPTH  = 1024,
    parameter int CNT_W      = 16,
    localparam int HLW = $clog2(HDR_DEPTH) + 1,
    localparam int DLW = $clog2(DATA_DEPTH) + 1,
    localparam int GLW = $clog2(GEN_DEPTH) + 1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_last,
    input logic           hdr_rd_en,
    input logic [HLW-1:0] hdr_level,
    input logic [DLW-1:0] data_level,
    input logic [GLW-1:0] gen_level,
    input logic [CNT_W-1:0] drop_cnt
);
    assert_hdr_rise_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (hdr_level > $past(hdr_level)) |-> $past(in_valid && in_last));
    assert_data_rise_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (data_level > $past(data_level)) |-> $past(in_valid && in_last));
    assert_gen_rise_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (gen_level > $past(gen_level)) |-> $past(in_valid && in_last));
    assert_drop_step_R7: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt != $past(drop_cnt)) |->
        ((drop_cnt == $past(drop_cnt) + 1'b1) && $past(in_valid && in_last)));
    assert_hdr_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(hdr_level) <= HDR_DEPTH);
    assert_data_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(data_level) <= DATA_DEPTH);
    assert_gen_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(gen_level) <= GEN_DEPTH);
    assert_split_pairs_R2: assert property (@(posedge clk) disable iff (rst)
        (data_level > $past(data_level)) |-> (int'(hdr_level) >= int'($past(hdr_level)) + 41));
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (hdr_rd_en && hdr_level == '0 && !(in_valid && in_last)) |=> (hdr_level == '0));
endmodule

bind rtss_splitter rtss_splitter_chk #(
    .HDR_DEPTH(HDR_DEPTH), .DATA_DEPTH(DATA_DEPTH), .GEN_DEPTH(GEN_DEPTH), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_rtss_splitter.sv
module test_rtss_splitter;
    localparam int NSLOT = 4, HD = 256, DD = 2048, GD = 1024;
    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_last = 0;
    logic [7:0] in_data = 0;
    logic [NSLOT*16-1:0] cfg_port;
    logic [NSLOT-1:0] cfg_en;
    logic hdr_rd_en = 0, data_rd_en = 0, gen_rd_en = 0;
    logic [7:0] hdr_rd_data, data_rd_data, gen_rd_data;
    logic [8:0] hdr_level;
    logic [11:0] data_level;
    logic [10:0] gen_level;
    logic [15:0] drop_cnt;

    int n_chk = 0, n_bad = 0, exp_drop = 0;
    bit done = 0;
    logic [7:0] hq[$], dq[$], gq[$];
    logic [15:0] ports [NSLOT] = '{16'd5000, 16'd5001, 16'd5002, 16'd6000};
    logic [NSLOT-1:0] ens = 4'b0111;

    always #4 clk = ~clk;

    rtss_splitter i_rtss_splitter (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bq_t mk(input logic [15:0] et, input logic [7:0] vi,
                               input logic [7:0] pr, input logic [15:0] dp, input int pay);
        bq_t f;
        for (int i = 0; i < 42 + pay; i++) f.push_back(8'($urandom));
        f[12] = et[15:8]; f[13] = et[7:0]; f[14] = vi; f[23] = pr;
        f[36] = dp[15:8]; f[37] = dp[7:0];
        return f;
    endfunction

    function automatic bit bench_match(input bq_t f);
        bit hit = 0;
        if (f.size() < 42) return 0;
        if (f[12] != 8'h08 || f[13] != 8'h00 || f[14] != 8'h45 || f[23] != 8'd17) return 0;
        for (int s = 0; s < NSLOT; s++)
            if (ens[s] && ports[s] == {f[36], f[37]}) hit = 1;
        return hit;
    endfunction

    task automatic send(input bq_t f, input string req);
        int hl = hq.size(), dl = dq.size(), gl = gq.size();
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            if (i == f.size() / 2 && i > 0) begin
                chk({req, " R6 mid-frame hdr level"}, int'(hdr_level), hl);
                chk({req, " R6 mid-frame data level"}, int'(data_level), dl);
                chk({req, " R6 mid-frame gen level"}, int'(gen_level), gl);
            end
            in_valid = 1; in_data = f[i]; in_last = (i == f.size() - 1);
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
        if (bench_match(f)) begin
            if (hl + 42 <= HD && dl + f.size() - 42 <= DD) begin
                for (int i = 0; i < f.size(); i++)
                    if (i < 42) hq.push_back(f[i]); else dq.push_back(f[i]);
            end else exp_drop++;
        end else begin
            if (gl + f.size() <= GD) foreach (f[i]) gq.push_back(f[i]);
            else exp_drop++;
        end
        chk({req, " R7 drop count"}, int'(drop_cnt), exp_drop);
        chk({req, " R2 hdr level"}, int'(hdr_level), hq.size());
        chk({req, " R2 data level"}, int'(data_level), dq.size());
        chk({req, " R3 gen level"}, int'(gen_level), gq.size());
    endtask

    function automatic int lvl(input int sel);
        return sel == 0 ? int'(hdr_level) : sel == 1 ? int'(data_level) : int'(gen_level);
    endfunction

    task automatic drain(input int sel, input string req);
        int e;
        while (lvl(sel) != 0) begin
            @(negedge clk);
            hdr_rd_en = (sel == 0); data_rd_en = (sel == 1); gen_rd_en = (sel == 2);
            @(negedge clk);
            hdr_rd_en = 0; data_rd_en = 0; gen_rd_en = 0;
            if (sel == 0 && hq.size() > 0) e = int'(hq.pop_front());
            else if (sel == 1 && dq.size() > 0) e = int'(dq.pop_front());
            else if (sel == 2 && gq.size() > 0) e = int'(gq.pop_front());
            else e = -1;
            chk({req, " R8 read byte"}, sel == 0 ? int'(hdr_rd_data) :
                sel == 1 ? int'(data_rd_data) : int'(gen_rd_data), e);
            if (e < 0) break;
        end
        chk({req, " R8 model empty"}, sel == 0 ? hq.size() : sel == 1 ? dq.size() : gq.size(), 0);
    endtask

    task automatic drain_all(input string req);
        drain(0, req); drain(1, req); drain(2, req);
    endtask

    initial begin
        bq_t f;
        void'($urandom(32'd4242));
        for (int s = 0; s < NSLOT; s++) cfg_port[s*16 +: 16] = ports[s];
        cfg_en = ens;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset hdr level", int'(hdr_level), 0);
        chk("R9 reset data level", int'(data_level), 0);
        chk("R9 reset gen level", int'(gen_level), 0);
        chk("R9 reset drop", int'(drop_cnt), 0);

        // R8: read strobe on empty ring ignored
        @(negedge clk); hdr_rd_en = 1; gen_rd_en = 1;
        @(negedge clk); hdr_rd_en = 0; gen_rd_en = 0;
        chk("R8 empty read hdr", int'(hdr_level), 0);
        chk("R8 empty read gen", int'(gen_level), 0);

        // directed
        send(mk(16'h0800, 8'h45, 8'd17, 16'd5001, 1024), "R1 R11 match 1024");
        send(mk(16'h0806, 8'h45, 8'd17, 16'd5001, 20), "R1 R3 wrong type");
        send(mk(16'h0800, 8'h46, 8'd17, 16'd5001, 20), "R4 ihl six");
        send(mk(16'h0800, 8'h45, 8'd6,  16'd5001, 20), "R1 R3 tcp proto");
        send(mk(16'h0800, 8'h45, 8'd17, 16'd6000, 20), "R5 disabled slot");
        send(mk(16'h0800, 8'h45, 8'd17, 16'd5002, 0), "R10 header only");
        f = mk(16'h0800, 8'h45, 8'd17, 16'd5000, 0);
        void'(f.pop_back());
        send(f, "R3 41-byte frame");
        drain_all("R2 R3 directed");

        // R11: payload ring holds two full frames, third dropped
        for (int k = 0; k < 3; k++) send(mk(16'h0800, 8'h45, 8'd17, 16'd5000, 1024), "R11 R7 data fill");
        chk("R11 drops after three", int'(drop_cnt), 1);
        drain_all("R7 after data overflow");

        // R7: header ring overflow with payload room
        for (int k = 0; k < 7; k++) send(mk(16'h0800, 8'h45, 8'd17, 16'd5002, 10), "R7 hdr fill");
        chk("R7 header ring full level", int'(hdr_level), 252);
        drain_all("R7 after hdr overflow");

        // R7: general ring overflow
        send(mk(16'h1234, 8'h45, 8'd17, 16'd1, 1100), "R7 gen too big");
        drain_all("R7 after gen overflow");

        // random
        for (int n = 0; n < 60; n++) begin
            int kind = $urandom % 6;
            int pay = $urandom % 150;
            logic [15:0] dp = ports[$urandom % 3];
            case (kind)
                0: f = mk(16'h0800, 8'h45, 8'd17, dp, pay);
                1: f = mk(16'h86DD, 8'h45, 8'd17, dp, pay);
                2: f = mk(16'h0800, 8'h4F, 8'd17, dp, pay);
                3: f = mk(16'h0800, 8'h45, 8'd1, dp, pay);
                4: f = mk(16'h0800, 8'h45, 8'd17, 16'd6000 + 16'($urandom % 3), pay);
                default: begin
                    f = mk(16'h0800, 8'h45, 8'd17, dp, 0);
                    repeat (1 + $urandom % 41) void'(f.pop_back());
                end
            endcase
            send(f, "R1 R2 R3 random");
            if (n % 5 == 4) drain_all("R8 random drain");
        end
        drain_all("R8 final drain");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule